// File: doc/BRIEF.md
# Multi-Hart Machine Timer

This block is the machine timer that sits beside a group of harts on a chip. It keeps one free-running 64-bit time counter. For every hart it serves, it keeps one 64-bit compare register. Each hart gets one level-sensitive timer interrupt line. The line is high whenever the current time has reached that hart's compare value. The counter advances by one on each cycle in which the timebase tick input is high.

Software reaches the compare registers and the counter through a simple request/response register bus. The bus supports 32-bit and 64-bit accesses. A 32-bit write to one half of a register leaves the other stored half untouched. Compare registers sit at 8-byte slots, and the slot number is the absolute hart number. Each instance is given a base hart number and a hart count, so that several instances can serve different sockets of a larger system. Accesses to harts outside the instance's range, and to unsupported offsets, are rejected with an error response.

Top module: `htmr_top`

## Requirements
- R1: Each hart has its own 64-bit compare register and interrupt line. `irq[i]` is high exactly when the time counter is greater than or equal to compare register `i`, as unsigned numbers. The line stays high while that holds, and it clears only when a compare or time write moves the compare value above the time.
- R2: Address bits `[ADDR_W-1:3]` hold the slot number. Slot `s` selects local compare register `s - HART_BASE` when `HART_BASE <= s < HART_BASE + N_HARTS`. Any other slot, except the time slot, is rejected.
- R3: Within a slot, offset 0 with `req_wide=1` is the full 64-bit value. Offset 0 with `req_wide=0` is the low word, and offset 4 with `req_wide=0` is the high word. Every other offset, and a 64-bit access at offset 4, is unsupported.
- R4: A 32-bit write to the low word keeps the stored high word, and a 32-bit write to the high word keeps the stored low word. Only `req_wdata[31:0]` is used.
- R5: A 64-bit read returns the whole register. A 32-bit read returns the selected word in `rsp_rdata[31:0]`, with the upper 32 bits zero. Writes respond with zero data.
- R6: After reset, every compare register and the time counter are 0, so every `irq` bit is high, and `rsp_valid` is low.
- R7: The time counter sits at byte offset `TIME_OFS`, which is 8-aligned, and uses the same offset and width rules as a compare slot. It adds 1 on each cycle with `tick` high. A write in the same cycle takes priority over the tick. After any time write, every hart's interrupt reflects the new time.
- R8: An unsupported or out-of-range access gives `rsp_err=1` with `rsp_rdata=0`. A write of that kind changes no register.
- R9: Every request cycle (`req_valid=1`) produces exactly one `rsp_valid` pulse in the following cycle. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable; the counter adds one on each cycle in which it is high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | ADDR_W | Byte address inside the block |
| req_wdata | input | 64 | Write data (bits 31:0 for 32-bit writes) |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Previous request was unsupported or out of range |
| rsp_rdata | output | 64 | Read data |
| irq | output | N_HARTS | Per-hart timer interrupt, level-sensitive |

## Verification
A response, whether data or error, is registered and is due one cycle after the request cycle. The bench drives each request on a falling edge and samples the response on the next falling edge. Compare and time writes take effect at the request's rising edge, and the interrupt is a combinational compare of registered values, so `irq` is checked on that same following falling edge. A tick counts at the rising edge inside its high window, and its effect on `irq` and on a later time read is checked one falling edge later. The sweep covers every slot, offset and width of a four-hart instance with base 2, against values the bench model computes.

// File: rtl/htmr_pkg.sv
package htmr_pkg;

   localparam int WORD_W = 64;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_CMP  = 2'd1,
      TGT_TIME = 2'd2
   } htmr_tgt_e;

   // Combine new write data with a stored 64-bit word according to access size/half.
   function automatic logic [WORD_W-1:0] merge_word(
      input logic [WORD_W-1:0] old_v,
      input logic [WORD_W-1:0] data,
      input logic              wide,
      input logic              upper
   );
      if (wide)       return data;
      else if (upper) return {data[31:0], old_v[31:0]};
      else            return {old_v[63:32], data[31:0]};
   endfunction

endpackage

// File: rtl/htmr_addr_dec.sv
module htmr_addr_dec
   import htmr_pkg::*;
#(
   parameter int N_HARTS   = 4,
   parameter int HART_BASE = 2,
   parameter int ADDR_W    = 16,
   parameter int TIME_OFS  = 32'h7FF8,
   parameter int IDX_W     = 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wide,
   output htmr_tgt_e         tgt,
   output logic              upper,
   output logic [IDX_W-1:0]  idx,
   output logic              bad
);
   localparam int SLOT_W = ADDR_W - 3;
   localparam logic [SLOT_W-1:0] LO_S   = SLOT_W'(HART_BASE);
   localparam logic [SLOT_W-1:0] HI_S   = SLOT_W'(HART_BASE + N_HARTS);
   localparam logic [SLOT_W-1:0] TIME_S = SLOT_W'(TIME_OFS / 8);

   logic [SLOT_W-1:0] slot;
   logic [2:0]        ofs;
   logic              ofs_ok;
   logic              hit_time;
   logic              hit_cmp;

   assign slot     = addr[ADDR_W-1:3];
   assign ofs      = addr[2:0];
   assign ofs_ok   = (ofs == 3'd0) || ((ofs == 3'd4) && !wide);
   assign hit_time = (slot == TIME_S);
   assign hit_cmp  = (slot >= LO_S) && (slot < HI_S);

   always_comb begin
      tgt = TGT_NONE;
      if (ofs_ok && hit_time)     tgt = TGT_TIME;
      else if (ofs_ok && hit_cmp) tgt = TGT_CMP;
   end

   assign bad   = (tgt == TGT_NONE);
   assign upper = ofs[2];
   assign idx   = IDX_W'(slot - LO_S);
endmodule

// File: rtl/htmr_time_ctr.sv
module htmr_time_ctr
   import htmr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              wr_wide,
   input  logic              wr_upper,
   input  logic [WORD_W-1:0] wr_data,
   output logic [WORD_W-1:0] time_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     time_q <= '0;
      else if (wr_en) time_q <= merge_word(time_q, wr_data, wr_wide, wr_upper);
      else if (tick)  time_q <= time_q + WORD_W'(1);
   end
endmodule

// File: rtl/htmr_cmp_slot.sv
module htmr_cmp_slot
   import htmr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_wide,
   input  logic              wr_upper,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [WORD_W-1:0] time_now,
   output logic [WORD_W-1:0] cmp_q,
   output logic              fire
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cmp_q <= '0;
      else if (wr_en) cmp_q <= merge_word(cmp_q, wr_data, wr_wide, wr_upper);
   end

   // Level output: re-evaluated every cycle, so time writes affect all harts at once.
   assign fire = (time_now >= cmp_q);
endmodule

// File: rtl/htmr_top.sv
module htmr_top
   import htmr_pkg::*;
#(
   parameter int N_HARTS   = 4,
   parameter int HART_BASE = 2,
   parameter int ADDR_W    = 16,
   parameter int TIME_OFS  = 32'h7FF8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic                req_wide,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [63:0]         req_wdata,
   output logic                rsp_valid,
   output logic                rsp_err,
   output logic [63:0]         rsp_rdata,
   output logic [N_HARTS-1:0]  irq
);
   localparam int IDX_W  = (N_HARTS > 1) ? $clog2(N_HARTS) : 1;
   localparam int SLOT_W = ADDR_W - 3;

   // Elaboration-time parameter checks
   if (N_HARTS < 1 || N_HARTS > 8) begin : g_bad_harts
      $error("htmr_top: N_HARTS must be 1..8");
   end
   if (TIME_OFS % 8 != 0) begin : g_bad_time_align
      $error("htmr_top: TIME_OFS must be 8-byte aligned");
   end
   if ((TIME_OFS / 8) >= HART_BASE && (TIME_OFS / 8) < HART_BASE + N_HARTS) begin : g_time_overlap
      $error("htmr_top: time slot overlaps compare slots");
   end
   if (ADDR_W < 4 || HART_BASE < 0 || (HART_BASE + N_HARTS) >= (1 << SLOT_W)
       || (TIME_OFS / 8) >= (1 << SLOT_W)) begin : g_bad_span
      $error("htmr_top: address width too small for the configured slots");
   end

   htmr_tgt_e        tgt;
   logic             upper;
   logic [IDX_W-1:0] idx;
   logic             bad;
   logic             do_wr;
   logic [63:0]      time_q;
   logic [63:0]      cmp_arr [N_HARTS];
   logic [63:0]      sel_v;
   logic [63:0]      rd_v;

   htmr_addr_dec #(
      .N_HARTS(N_HARTS), .HART_BASE(HART_BASE), .ADDR_W(ADDR_W),
      .TIME_OFS(TIME_OFS), .IDX_W(IDX_W)
   ) u_dec (
      .addr(req_addr), .wide(req_wide), .tgt(tgt), .upper(upper), .idx(idx), .bad(bad)
   );

   assign do_wr = req_valid && req_write && !bad;

   htmr_time_ctr u_time (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .wr_en(do_wr && (tgt == TGT_TIME)), .wr_wide(req_wide), .wr_upper(upper),
      .wr_data(req_wdata), .time_q(time_q)
   );

   for (genvar i = 0; i < N_HARTS; i++) begin : g_slot
      htmr_cmp_slot u_slot (
         .clk(clk), .rst_n(rst_n),
         .wr_en(do_wr && (tgt == TGT_CMP) && (idx == IDX_W'(i))),
         .wr_wide(req_wide), .wr_upper(upper), .wr_data(req_wdata),
         .time_now(time_q), .cmp_q(cmp_arr[i]), .fire(irq[i])
      );
   end

   always_comb begin
      sel_v = '0;
      if (tgt == TGT_TIME)     sel_v = time_q;
      else if (tgt == TGT_CMP) sel_v = cmp_arr[idx];
      if (bad || req_write)    rd_v = '0;
      else if (req_wide)       rd_v = sel_v;
      else if (upper)          rd_v = {32'b0, sel_v[63:32]};
      else                     rd_v = {32'b0, sel_v[31:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && bad;
         rsp_rdata <= req_valid ? rd_v : '0;
      end
   end
endmodule

// File: rtl/htmr_chk.sv
module htmr_chk #(
   parameter int N_HARTS = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick,
   input logic               req_valid,
   input logic               req_write,
   input logic               rsp_valid,
   input logic               rsp_err,
   input logic [63:0]        rsp_rdata,
   input logic [N_HARTS-1:0] irq,
   input logic [63:0]        time_now
);
   a_r9_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r9_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r8_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_valid && rsp_rdata == 64'd0));

   a_r7_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !req_valid) |=> (time_now == $past(time_now) + 64'd1));

   a_r1_irq_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write) |=> ((irq & $past(irq)) == $past(irq)));
endmodule

bind htmr_top htmr_chk #(.N_HARTS(N_HARTS)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
   .req_write(req_write), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
   .rsp_rdata(rsp_rdata), .irq(irq), .time_now(time_q)
);

// File: tb/sim_htmr_top.sv
`timescale 1ns/1ps
module sim_htmr_top;
   localparam int NH     = 4;
   localparam int BASE   = 2;
   localparam int AW     = 16;
   localparam int TOFS   = 32'h7FF8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic          req_wide = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [63:0]   req_wdata = '0;
   logic          rsp_valid;
   logic          rsp_err;
   logic [63:0]   rsp_rdata;
   logic [NH-1:0] irq;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [63:0] cmp_m [NH];
   logic [63:0] time_m;

   always #10 clk = ~clk;

   htmr_top #(.N_HARTS(NH), .HART_BASE(BASE), .ADDR_W(AW), .TIME_OFS(TOFS)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .req_valid(req_valid),
      .req_write(req_write), .req_wide(req_wide), .req_addr(req_addr),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
      .rsp_rdata(rsp_rdata), .irq(irq)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [NH-1:0] exp_irq();
      logic [NH-1:0] e;
      for (int i = 0; i < NH; i++) e[i] = (time_m >= cmp_m[i]);
      return e;
   endfunction

   function automatic logic [63:0] mrg(input logic [63:0] o, input logic [63:0] d,
                                       input logic w, input logic up);
      if (w) return d;
      if (up) return {d[31:0], o[31:0]};
      return {o[63:32], d[31:0]};
   endfunction

   task automatic bus(input logic wr, input logic wide, input logic [AW-1:0] a,
                      input logic [63:0] d, output logic [63:0] rd, output logic er);
      req_valid = 1'b1; req_write = wr; req_wide = wide; req_addr = a; req_wdata = d;
      @(negedge clk);
      check("R9 rsp_valid", {63'b0, rsp_valid}, 64'd1);
      rd = rsp_rdata; er = rsp_err;
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   function automatic logic [AW-1:0] cmp_addr(input int h, input int ofs);
      return AW'((BASE + h) * 8 + ofs);
   endfunction

   task automatic cmp_wr(input int h, input logic wide, input logic up, input logic [63:0] d);
      logic [63:0] r; logic e;
      bus(1'b1, wide, cmp_addr(h, up ? 4 : 0), d, r, e);
      cmp_m[h] = mrg(cmp_m[h], d, wide, up);
      check("R8 valid write no err", {63'b0, e}, 64'd0);
      check("R1 irq after compare write", {60'b0, irq}, {60'b0, exp_irq()});
   endtask

   task automatic time_wr(input logic wide, input logic up, input logic [63:0] d);
      logic [63:0] r; logic e;
      bus(1'b1, wide, AW'(TOFS + (up ? 4 : 0)), d, r, e);
      time_m = mrg(time_m, d, wide, up);
      check("R7 irq after time write", {60'b0, irq}, {60'b0, exp_irq()});
   endtask

   task automatic rd64(input logic [AW-1:0] a, input string tag, input logic [63:0] exp);
      logic [63:0] r; logic e;
      bus(1'b0, 1'b1, a, 64'd0, r, e);
      check(tag, r, exp);
   endtask

   task automatic pulse_tick();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      time_m = time_m + 64'd1;
      check("R7 irq after tick", {60'b0, irq}, {60'b0, exp_irq()});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] r;
      logic e;
      for (int i = 0; i < NH; i++) cmp_m[i] = 64'd0;
      time_m = 64'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: reset state
      check("R6 irq all high at reset", {60'b0, irq}, {60'b0, {NH{1'b1}}});
      check("R6 no response at reset", {63'b0, rsp_valid}, 64'd0);
      for (int h = 0; h < NH; h++) rd64(cmp_addr(h, 0), "R6 compare resets to 0", 64'd0);
      rd64(AW'(TOFS), "R6 time resets to 0", 64'd0);

      // R1/R2: distinct 64-bit compare values per hart, read back per hart
      for (int h = 0; h < NH; h++)
         cmp_wr(h, 1'b1, 1'b0, {32'h0000_0001 + 32'(h), 32'h8000_0000 + 32'(h) * 32'h10});
      for (int h = 0; h < NH; h++) rd64(cmp_addr(h, 0), "R2 compare per hart", cmp_m[h]);

      // R4: half-word merges
      cmp_wr(1, 1'b0, 1'b0, 64'hDEAD_BEEF_1234_5678);
      rd64(cmp_addr(1, 0), "R4 low write keeps high", cmp_m[1]);
      cmp_wr(2, 1'b0, 1'b1, 64'hFFFF_FFFF_CAFE_0003);
      rd64(cmp_addr(2, 0), "R4 high write keeps low", cmp_m[2]);

      // R7: time writes, full and by halves, change every hart's irq
      time_wr(1'b1, 1'b0, 64'h0000_0002_2000_0000);
      rd64(AW'(TOFS), "R7 time 64-bit write", time_m);
      time_wr(1'b0, 1'b0, 64'hAAAA_AAAA_0000_0001);
      rd64(AW'(TOFS), "R7 time low write merges", time_m);
      time_wr(1'b0, 1'b1, 64'h0000_0000_0000_0005);
      rd64(AW'(TOFS), "R7 time high write merges", time_m);
      time_wr(1'b1, 1'b0, 64'd0);

      // R1/R7: ticks cross a compare value
      cmp_wr(0, 1'b1, 1'b0, 64'h100);
      time_wr(1'b1, 1'b0, 64'hFE);
      check("R1 irq0 low before compare", {63'b0, irq[0]}, 64'd0);
      pulse_tick();
      pulse_tick();
      check("R1 irq0 high at compare", {63'b0, irq[0]}, 64'd1);
      for (int k = 0; k < 3; k++) pulse_tick();
      check("R1 irq0 stays high", {63'b0, irq[0]}, 64'd1);
      rd64(AW'(TOFS), "R7 time after ticks", time_m);

      // R7: write wins over a tick in the same cycle
      tick = 1'b1;
      bus(1'b1, 1'b1, AW'(TOFS), 64'h50, r, e);
      tick = 1'b0;
      time_m = 64'h50;
      check("R7 irq after write-over-tick", {60'b0, irq}, {60'b0, exp_irq()});
      rd64(AW'(TOFS), "R7 write beats tick", time_m);

      // R2/R3/R5/R8: sweep every slot, offset and width
      for (int s = 0; s < 8; s++) begin
         for (int o = 0; o < 8; o++) begin
            for (int w = 0; w < 2; w++) begin
               logic ok;
               logic [63:0] ev;
               ok = (s >= BASE) && (s < BASE + NH) && ((o == 0) || (o == 4 && w == 0));
               ev = 64'd0;
               if (ok) begin
                  if (w == 1)      ev = cmp_m[s - BASE];
                  else if (o == 4) ev = {32'b0, cmp_m[s - BASE][63:32]};
                  else             ev = {32'b0, cmp_m[s - BASE][31:0]};
               end
               bus(1'b0, w[0], AW'(s * 8 + o), 64'd0, r, e);
               check("R3 R8 sweep err", {63'b0, e}, {63'b0, !ok});
               check("R2 R5 sweep data", r, ev);
            end
         end
      end
      bus(1'b0, 1'b1, AW'(TOFS + 4), 64'd0, r, e);
      check("R3 wide read at time+4 rejected", {63'b0, e}, 64'd1);
      bus(1'b0, 1'b0, AW'(TOFS + 4), 64'd0, r, e);
      check("R5 time high word read", r, {32'b0, time_m[63:32]});

      // R8: rejected writes change nothing
      for (int s = 0; s < 8; s++) begin
         if (s < BASE || s >= BASE + NH) begin
            bus(1'b1, 1'b1, AW'(s * 8), 64'hFFFF_FFFF_FFFF_FFFF, r, e);
            check("R8 out-of-range write err", {63'b0, e}, 64'd1);
         end
      end
      bus(1'b1, 1'b0, cmp_addr(0, 2), 64'hFFFF_FFFF, r, e);
      check("R8 bad offset write err", {63'b0, e}, 64'd1);
      bus(1'b1, 1'b1, cmp_addr(3, 4), 64'd0, r, e);
      check("R8 wide write at offset 4 err", {63'b0, e}, 64'd1);
      for (int h = 0; h < NH; h++) rd64(cmp_addr(h, 0), "R8 compare unchanged", cmp_m[h]);
      check("R8 irq unchanged", {60'b0, irq}, {60'b0, exp_irq()});

      // R1: rewriting compare to the future clears the line
      cmp_wr(0, 1'b1, 1'b0, 64'h1000);
      check("R1 irq0 cleared by future compare", {63'b0, irq[0]}, 64'd0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule